// File: doc/BRIEF.md
# Quad-View Frame Composition Controller

This block sits between four pixel streams and the frame-store write queues of a four-camera viewer. Each stream carries a pixel, a valid flag and a frame-start flag. The block works out where each accepted pixel belongs in one output picture, which is FRAME_W x FRAME_H (1280 x 720 by default). It then issues a write for that location on the stream's own write lane: a pixel, a linear address and a strobe.

The block has two modes. In quad mode, every stream has already been shrunk to half width and half height, and each one fills its own quarter of the output picture. In single mode, one stream chosen by a two-bit select keeps its full size and fills the whole picture, and the other three streams produce no writes.

Each lane keeps its own position counters. Each lane also samples the mode and select controls only at its own frame start, so a control change never splits a frame across two layouts.

Top module: `quad_compose`

## Requirements
- R1: While rstN is low, and after reset until a lane sees its first frame start, outWrite stays 0 on every lane.
- R2: Valid pixels that arrive on a lane before its first frame start produce no write.
- R3: With singleMode at 0, the k-th accepted pixel of a lane's frame (k counted from 0) is written to address (k / QW + QH*(lane/2))*FRAME_W + k % QW + QW*(lane%2), where QW = FRAME_W/2 and QH = FRAME_H/2. This places lane 0 top-left, lane 1 top-right, lane 2 bottom-left and lane 3 bottom-right.
- R4: A quad-mode frame holds QW*QH pixels, and a single-mode frame holds FRAME_W*FRAME_H pixels. Valid pixels after the last one and before the next frame start produce no write.
- R5: With singleMode at 1, the lane whose index equals selIn (00 selects lane 0, 01 lane 1, 10 lane 2, 11 lane 3) writes its k-th pixel to address k, which is row*FRAME_W + column of a full-size raster.
- R6: With singleMode at 1, the lanes that are not selected never assert outWrite for that frame.
- R7: A lane samples singleMode and selIn only on a cycle where inValid and inSof are both 1. A change on any other cycle leaves the lane's current frame unchanged.
- R8: A write appears on outWrite, outAddr and outPix exactly one clock after the pixel is accepted, with the pixel value unchanged.
- R9: A cycle with inValid low on a lane neither writes nor advances that lane's position.
- R10: Lanes are independent: a frame start or a pixel on one lane does not move another lane's position.
- R11: A frame start arriving in the middle of a frame restarts the lane at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| singleMode | input | 1 | 1 selects single-picture mode, 0 selects quad mode |
| selIn | input | 2 | Lane shown in single mode |
| inPix | input | 4 x PIX_W | Pixel of each input lane |
| inValid | input | 4 | Pixel valid of each lane |
| inSof | input | 4 | Frame start of each lane, qualified by inValid |
| outPix | output | 4 x PIX_W | Pixel written by each lane |
| outAddr | output | 4 x ADDR_W | Linear frame-store address of each lane's write |
| outWrite | output | 4 | Write strobe of each lane |

## Verification
Some properties are checked on every cycle by assertions. These are the one-cycle relation between an accepted pixel and its write, including the unchanged pixel value. They also cover the silence of idle cycles, the address of the first pixel of each frame in both modes, and the absence of writes from unselected lanes in single mode. Other behaviours depend on a whole frame of history and can only be shown by the bench scenarios. These are the complete quadrant address pattern, the cut-off after the last pixel of a frame, sampling of the controls only at frame start, restart in the middle of a frame, and independence between lanes with different gaps and start times.

// File: rtl/quad_compose_pkg.sv
package quad_compose_pkg;
  localparam int LANES = 4;

  // Per-pixel strobes from a lane's control to its datapath
  typedef struct packed {
    logic write;    // accept this pixel and write it
    logic restart;  // this pixel is the first of a frame
    logic quad;     // quadrant placement in force for this pixel
  } laneStrobe_t;
endpackage

// File: rtl/quad_compose_ctrl.sv
module quad_compose_ctrl
  import quad_compose_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        singleMode,
  input  logic [1:0]  selIn,
  input  logic        lastPix,
  output laneStrobe_t strobe
);
  logic activeQ, onQ, quadQ;
  logic startNow, newOn, effActive, effOn;

  always_comb begin
    startNow  = inValid && inSof;
    newOn     = !singleMode || (selIn == 2'(LANE));
    effActive = startNow || activeQ;
    effOn     = startNow ? newOn : onQ;
    strobe.write   = inValid && effActive && effOn;
    strobe.restart = startNow;
    strobe.quad    = startNow ? !singleMode : quadQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      onQ     <= 1'b0;
      quadQ   <= 1'b0;
    end else begin
      if (startNow) begin
        onQ   <= newOn;
        quadQ <= !singleMode;
      end
      activeQ <= effActive && !(strobe.write && lastPix);
    end
  end
endmodule

// File: rtl/quad_compose_dp.sv
module quad_compose_dp
  import quad_compose_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int FRAME_W = 1280,
  parameter int FRAME_H = 720,
  parameter int ADDR_W  = 20,
  parameter int LANE    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [PIX_W-1:0]  inPix,
  output logic              lastPix,
  output logic [PIX_W-1:0]  outPix,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outWrite
);
  localparam int COL_W   = $clog2(FRAME_W);
  localparam int ROW_W   = $clog2(FRAME_H);
  localparam int QUAD_W  = FRAME_W / 2;
  localparam int QUAD_H  = FRAME_H / 2;
  localparam int COL_OFF = (LANE % 2) * QUAD_W;
  localparam int ROW_OFF = (LANE / 2) * QUAD_H;

  logic [COL_W-1:0]  colQ, curCol, lastCol, colPos;
  logic [ROW_W-1:0]  rowQ, curRow, lastRow, rowPos;
  logic              endLine;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    curCol   = strobe.restart ? '0 : colQ;
    curRow   = strobe.restart ? '0 : rowQ;
    lastCol  = strobe.quad ? COL_W'(QUAD_W - 1) : COL_W'(FRAME_W - 1);
    lastRow  = strobe.quad ? ROW_W'(QUAD_H - 1) : ROW_W'(FRAME_H - 1);
    endLine  = (curCol == lastCol);
    lastPix  = endLine && (curRow == lastRow);
    colPos   = curCol + (strobe.quad ? COL_W'(COL_OFF) : '0);
    rowPos   = curRow + (strobe.quad ? ROW_W'(ROW_OFF) : '0);
    addrNext = ADDR_W'(rowPos) * ADDR_W'(FRAME_W) + ADDR_W'(colPos);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colQ     <= '0;
      rowQ     <= '0;
      outWrite <= 1'b0;
      outPix   <= '0;
      outAddr  <= '0;
    end else begin
      outWrite <= strobe.write;
      if (strobe.write) begin
        colQ    <= endLine ? '0 : curCol + 1'b1;
        rowQ    <= endLine ? curRow + 1'b1 : curRow;
        outPix  <= inPix;
        outAddr <= addrNext;
      end
    end
  end
endmodule

// File: rtl/quad_compose.sv
module quad_compose
  import quad_compose_pkg::*;
#(
  parameter int PIX_W   = 24,
  parameter int FRAME_W = 1280,
  parameter int FRAME_H = 720,
  localparam int ADDR_W = $clog2(FRAME_W * FRAME_H)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        singleMode,
  input  logic [1:0]                  selIn,
  input  logic [LANES-1:0][PIX_W-1:0] inPix,
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0]            inSof,
  output logic [LANES-1:0][PIX_W-1:0] outPix,
  output logic [LANES-1:0][ADDR_W-1:0] outAddr,
  output logic [LANES-1:0]            outWrite
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    laneStrobe_t laneStrobe;
    logic        laneLast;

    quad_compose_ctrl #(.LANE(g)) u_ctrl (
      .clk(clk), .rstN(rstN), .inValid(inValid[g]), .inSof(inSof[g]),
      .singleMode(singleMode), .selIn(selIn), .lastPix(laneLast),
      .strobe(laneStrobe)
    );

    quad_compose_dp #(
      .PIX_W(PIX_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H),
      .ADDR_W(ADDR_W), .LANE(g)
    ) u_dp (
      .clk(clk), .rstN(rstN), .strobe(laneStrobe), .inPix(inPix[g]),
      .lastPix(laneLast), .outPix(outPix[g]), .outAddr(outAddr[g]),
      .outWrite(outWrite[g])
    );
  end
endmodule

// File: rtl/quad_compose_checker.sv
module quad_compose_checker #(
  parameter int PIX_W   = 24,
  parameter int FRAME_W = 1280,
  parameter int FRAME_H = 720,
  parameter int ADDR_W  = 20
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  singleMode,
  input logic [1:0]            selIn,
  input logic [3:0][PIX_W-1:0]  inPix,
  input logic [3:0]            inValid,
  input logic [3:0]            inSof,
  input logic [3:0][PIX_W-1:0]  outPix,
  input logic [3:0][ADDR_W-1:0] outAddr,
  input logic [3:0]            outWrite
);
  for (genvar i = 0; i < 4; i++) begin : gChk
    localparam int BASE = (i / 2) * (FRAME_H / 2) * FRAME_W + (i % 2) * (FRAME_W / 2);

    assert_write_follows_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
      outWrite[i] |-> $past(inValid[i]));

    assert_pixel_passed_R8: assert property (@(posedge clk) disable iff (!rstN)
      outWrite[i] |-> outPix[i] == $past(inPix[i]));

    assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
      !inValid[i] |=> !outWrite[i]);

    assert_quad_origin_R3: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[i] && inSof[i] && !singleMode) |=> (outWrite[i] && outAddr[i] == ADDR_W'(BASE)));

    assert_single_origin_R5: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[i] && inSof[i] && singleMode && selIn == 2'(i)) |=> (outWrite[i] && outAddr[i] == '0));

    assert_unselected_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[i] && inSof[i] && singleMode && selIn != 2'(i)) |=> !outWrite[i]);
  end
endmodule

bind quad_compose quad_compose_checker #(
  .PIX_W(PIX_W), .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .singleMode(singleMode), .selIn(selIn),
  .inPix(inPix), .inValid(inValid), .inSof(inSof),
  .outPix(outPix), .outAddr(outAddr), .outWrite(outWrite)
);

// File: tb/quad_compose_bench.sv
module quad_compose_bench;
  localparam int FW = 8;
  localparam int FH = 4;
  localparam int QW = FW / 2;
  localparam int QH = FH / 2;
  localparam int PW = 8;
  localparam int AW = $clog2(FW * FH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic singleMode = 1'b0;
  logic [1:0] selIn = 2'd0;
  logic [3:0][PW-1:0] inPix = '0;
  logic [3:0] inValid = '0;
  logic [3:0] inSof = '0;
  logic [3:0][PW-1:0] outPix;
  logic [3:0][AW-1:0] outAddr;
  logic [3:0] outWrite;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int stepNo = 0;

  logic curMode = 1'b0;
  logic [1:0] curSel = 2'd0;
  logic [3:0] expW = '0;
  logic [3:0][AW-1:0] expA = '0;
  logic [3:0][PW-1:0] expP = '0;
  string prevTag = "R1";
  int bK[4];
  bit bAct[4];
  bit bOn[4];
  bit bQuad[4];

  quad_compose #(.PIX_W(PW), .FRAME_W(FW), .FRAME_H(FH)) u_quad_compose (
    .clk(clk), .rstN(rstN), .singleMode(singleMode), .selIn(selIn),
    .inPix(inPix), .inValid(inValid), .inSof(inSof),
    .outPix(outPix), .outAddr(outAddr), .outWrite(outWrite)
  );

  always #2 clk = ~clk;

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  // Compare outputs against what the previous step predicted
  task automatic checkPrev();
    for (int l = 0; l < 4; l++) begin
      checks++;
      if (outWrite[l] !== expW[l]) begin
        errors++;
        $display("FAIL %s lane %0d step %0d write: actual %b expected %b",
                 prevTag, l, stepNo, outWrite[l], expW[l]);
      end else if (expW[l]) begin
        checks++;
        if (outAddr[l] !== expA[l]) begin
          errors++;
          $display("FAIL %s lane %0d step %0d address: actual %0d expected %0d",
                   prevTag, l, stepNo, outAddr[l], expA[l]);
        end
        checks++;
        if (outPix[l] !== expP[l]) begin
          errors++;
          $display("FAIL %s/R8 lane %0d step %0d pixel: actual %0h expected %0h",
                   prevTag, l, stepNo, outPix[l], expP[l]);
        end
      end
    end
  endtask

  task automatic step(input logic [3:0] v, input logic [3:0] s, input string tag);
    int len;
    @(negedge clk);
    checkPrev();
    stepNo++;
    singleMode = curMode;
    selIn      = curSel;
    inValid    = v;
    inSof      = s;
    for (int l = 0; l < 4; l++) begin
      inPix[l] = PW'(l * 64 + (stepNo % 64));
      expW[l]  = 1'b0;
      expP[l]  = inPix[l];
      if (v[l]) begin
        if (s[l]) begin
          bK[l] = 0; bAct[l] = 1; bQuad[l] = !curMode;
          bOn[l] = !curMode || (curSel == 2'(l));
        end
        len = bQuad[l] ? QW * QH : FW * FH;
        if (bAct[l] && bOn[l] && bK[l] < len) begin
          expW[l] = 1'b1;
          if (bQuad[l])
            expA[l] = AW'((bK[l] / QW + (l / 2) * QH) * FW + bK[l] % QW + (l % 2) * QW);
          else
            expA[l] = AW'(bK[l]);
          bK[l]++;
        end
      end
    end
    prevTag = tag;
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin bK[l] = 0; bAct[l] = 0; bOn[l] = 0; bQuad[l] = 0; end
    inValid = 4'hF;
    // R1: no writes while in reset, even with valid input
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      checks++;
      if (outWrite !== 4'h0) begin
        errors++;
        $display("FAIL R1 reset write: actual %b expected 0000", outWrite);
      end
    end
    inValid = '0;
    @(negedge clk);
    rstN = 1'b1;

    // R2: valid pixels before any frame start
    for (int c = 0; c < 3; c++) step(4'hF, 4'h0, "R2");

    // R3: full quad frame on all lanes, then R4 overrun pixels
    curMode = 1'b0;
    step(4'hF, 4'hF, "R3");
    for (int c = 1; c < QW * QH; c++) step(4'hF, 4'h0, "R3");
    for (int c = 0; c < 3; c++) step(4'hF, 4'h0, "R4");

    // R9: lane-specific gaps in valid
    step(4'hF, 4'hF, "R9");
    for (int c = 1; c < 40; c++) begin
      logic [3:0] vm;
      for (int l = 0; l < 4; l++) vm[l] = (c % (l + 1)) == 0;
      step(vm, 4'h0, "R9");
    end

    // R10: staggered starts, R11: mid-frame restart of lane 0
    step(4'b0001, 4'b0001, "R10");
    step(4'b0011, 4'b0010, "R10");
    step(4'b0111, 4'b0100, "R10");
    step(4'b1111, 4'b1000, "R10");
    step(4'hF, 4'h0, "R10");
    step(4'hF, 4'b0001, "R11");
    for (int c = 0; c < 10; c++) step(4'hF, 4'h0, "R11");

    // R5/R6: single mode, every select value
    for (int sel = 0; sel < 4; sel++) begin
      curMode = 1'b1;
      curSel  = 2'(sel);
      step(4'hF, 4'hF, "R5");
      for (int c = 1; c < FW * FH; c++) step(4'hF, 4'h0, "R6");
      step(4'hF, 4'h0, "R4");
    end

    // R7: controls change mid-frame, take effect at the next start only
    curMode = 1'b0;
    step(4'hF, 4'hF, "R7");
    for (int c = 0; c < 3; c++) step(4'hF, 4'h0, "R7");
    curMode = 1'b1; curSel = 2'd1;
    for (int c = 0; c < 4; c++) step(4'hF, 4'h0, "R7");
    step(4'hF, 4'hF, "R7");
    for (int c = 0; c < 6; c++) step(4'hF, 4'h0, "R7");
    curMode = 1'b0;
    for (int c = 0; c < 4; c++) step(4'hF, 4'h0, "R7");

    step(4'h0, 4'h0, "R9");
    step(4'h0, 4'h0, "R9");
    finishRun();
  end
endmodule